// File: doc/BRIEF.md
# External trigger clock conditioner

This block turns an asynchronous trigger pin into a clean count stream for a timer. The pin first passes an optional inversion, so that either rising or falling pin edges are the active ones. It then goes through a ripple divider that is clocked by the pin itself and divides by 1, 2, 4 or 8. Because the divider runs ahead of the timer clock domain, a pin toggling faster than the timer can sample can still be counted once it has been divided down.

The divided level is brought into the timer clock domain by two flops. It then passes a glitch filter. The filter is paced by a sampling-tick enable and uses a down-counter: a new level is accepted only after enough consecutive ticks have seen it. An edge detector turns each rising edge of the filtered level into a one-cycle step. That step advances an up-counter while external clock mode and counting are both switched on.

All pins are plain control and status lines. There is no streamed data and no handshake.

Top module: `ext_trig_cond`

## Requirements
- R1: With `pol_inv` = 0 a low-to-high pin transition is the active edge. With `pol_inv` = 1 the pin is inverted first, so the counter advances on a high-to-low pin transition and not on the following low-to-high one.
- R2: `psc_sel` picks the divide ratio: 0 = /1, 1 = /2, 2 = /4, 3 = /8. At ratio 2^k (k>0) the divided level is bit k-1 of a 3-bit counter of active edges, so the counter advances once per 2^k active edges.
- R3: A change of `psc_sel` holds the divided level at 0 until the next timer clock edge and clears the edge divider. The next active edge at /2 therefore produces a count.
- R4: With `flt_code` = 0, a pin change made between clock edges appears on `trig_o` after the second following `clk` edge. The resulting count step appears after the third.
- R5: `flt_code` = 0 disables filtering: `trig_o` follows the synchronized divided level with no extra delay.
- R6: For a non-zero `flt_code`, `trig_o` takes a new level only on a cycle with `smp_tick` = 1 that completes N = `flt_code`+1 consecutive ticks, each seeing the synchronized level different from `trig_o`. A tick that sees agreement restarts the run, and no change happens on a cycle without a tick.
- R7: Each rising edge of `trig_o` advances `count_o` by exactly one, and the count never moves by more than one per cycle.
- R8: `count_o` holds its value whenever `ext_mode_en` or `cnt_en` is 0.
- R9: `count_o` wraps from its all-ones value to 0.
- R10: A synchronous `rst` clears `count_o` and `trig_o` to 0.
- R11: After division, the level must stay high and low for at least two `clk` periods each. A pin toggling every half `clk` period at /8 is counted exactly once per eight active edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | Asynchronous trigger pin |
| pol_inv | input | 1 | 1 = falling pin edges are active |
| psc_sel | input | PSC_W | Edge divide select (/1, /2, /4, /8) |
| flt_code | input | FLT_W | Filter length code, 0 = bypass |
| smp_tick | input | 1 | Filter sampling enable, one `clk` cycle wide |
| ext_mode_en | input | 1 | External clock mode enable |
| cnt_en | input | 1 | Counter enable |
| trig_o | output | 1 | Filtered, synchronized trigger level |
| count_o | output | CNT_W | Up-counter value |

## Verification
A divider left at the wrong phase shows up at the first active edge after the fault. `count_o` then steps one divided edge early or late, and the per-cycle reference comparison flags it within three clocks. A filter run counter that reloads wrongly moves the `trig_o` edge by whole tick periods, and this is visible the same cycle the reference level changes. A broken edge detector or enable gate gives extra, missing or double steps of `count_o`, and these are caught on the clock that follows the edge. A narrow counter instance is run alongside the full-width one so that a faulty wrap shows within the test length.

// File: rtl/etc_pkg.sv
`timescale 1ns/1ps
package etc_pkg;
  // Run length required by the glitch filter for a given code.
  function automatic int unsigned flt_len(input int unsigned code);
    return code + 1;
  endfunction
endpackage

// File: rtl/etc_prescaler.sv
`timescale 1ns/1ps
module etc_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_pol,
  input  logic [PSC_W-1:0] sel,
  output logic             div_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [PSC_W-1:0] sel_q;
  logic             clr_q;
  logic [DIV_W-1:0] ecnt;
  logic [DIV_W:0]   taps;

  // Clear request lives in the timer domain.
  always_ff @(posedge clk) begin
    sel_q <= sel;
    clr_q <= rst | (sel != sel_q);
  end

  // Edge counter runs on the conditioned pin itself.
  always_ff @(posedge pin_pol or posedge clr_q) begin
    if (clr_q) ecnt <= '0;
    else       ecnt <= ecnt + 1'b1;
  end

  assign taps = {ecnt, pin_pol};

  // Mask the tap while a new ratio is being applied.
  always_comb begin
    if (sel == sel_q) div_o = taps[sel];
    else              div_o = 1'b0;
  end
endmodule

// File: rtl/etc_resync.sv
`timescale 1ns/1ps
module etc_resync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/etc_filter.sv
`timescale 1ns/1ps
module etc_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [FLT_W-1:0] code,
  input  logic             tick,
  output logic             dout
);
  localparam int DC_W = $clog2((1 << FLT_W) + 1);

  logic [DC_W-1:0] run_q;
  logic [DC_W-1:0] run_len;
  logic            lvl_q;

  assign run_len = DC_W'(etc_pkg::flt_len(int'(code)));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      run_q <= run_len;
    end else if (code == '0) begin
      lvl_q <= din;
      run_q <= run_len;
    end else if (tick) begin
      if (din != lvl_q) begin
        if (run_q <= DC_W'(1)) begin
          lvl_q <= din;
          run_q <= run_len;
        end else begin
          run_q <= run_q - 1'b1;
        end
      end else begin
        run_q <= run_len;
      end
    end
  end

  assign dout = (code == '0) ? din : lvl_q;

  // R6: without a sampling tick the filtered level may not move.
  assert_tick_only_R6: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && !tick) |=> $stable(lvl_q));
endmodule

// File: rtl/etc_edge_counter.sv
`timescale 1ns/1ps
module etc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             ext_mode_en,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count_o
);
  logic lvl_q;
  logic step;

  assign step = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b0;
      count_o <= '0;
    end else begin
      lvl_q <= lvl;
      if (step && ext_mode_en && cnt_en) count_o <= count_o + 1'b1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(ext_mode_en && cnt_en) |=> $stable(count_o));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_o == $past(count_o)) ||
             (count_o == CNT_W'($past(count_o) + 1'b1)));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (count_o == '0));
endmodule

// File: rtl/ext_trig_cond.sv
`timescale 1ns/1ps
module ext_trig_cond #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2,
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             pol_inv,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic [FLT_W-1:0] flt_code,
  input  logic             smp_tick,
  input  logic             ext_mode_en,
  input  logic             cnt_en,
  output logic             trig_o,
  output logic [CNT_W-1:0] count_o
);
  logic pin_pol;
  logic divided;
  logic synced;

  assign pin_pol = pin_i ^ pol_inv;

  etc_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .pin_pol(pin_pol), .sel(psc_sel), .div_o(divided)
  );

  etc_resync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(divided), .dout(synced)
  );

  etc_filter #(.FLT_W(FLT_W)) u_flt (
    .clk(clk), .rst(rst), .din(synced), .code(flt_code), .tick(smp_tick),
    .dout(trig_o)
  );

  etc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .lvl(trig_o), .ext_mode_en(ext_mode_en),
    .cnt_en(cnt_en), .count_o(count_o)
  );
endmodule

// File: tb/test_ext_trig_cond.sv
`timescale 1ns/1ps
module test_ext_trig_cond;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       pol = 1'b0;
  logic [1:0] psc = 2'd0;
  logic [3:0] code = 4'd0;
  logic       tick = 1'b1;
  logic       ext = 1'b1;
  logic       cen = 1'b1;
  logic       trig, trig_w;
  logic [15:0] cnt;
  logic [3:0]  cnt_w;

  int compared = 0;
  int mismatched = 0;
  int ref_pe = 0;
  int tick_div = 1;
  int exp_total = 0;
  bit started = 0;

  // reference model state
  logic m_s1 = 0, m_s2 = 0, m_flt = 0, m_fq = 0;
  int   m_dc = 1;
  logic [15:0] m_cnt = '0;

  always #2.5 clk = ~clk;

  ext_trig_cond i_ext_trig_cond (
    .clk(clk), .rst(rst), .pin_i(pin), .pol_inv(pol), .psc_sel(psc),
    .flt_code(code), .smp_tick(tick), .ext_mode_en(ext), .cnt_en(cen),
    .trig_o(trig), .count_o(cnt)
  );

  ext_trig_cond #(.CNT_W(4)) i_ext_trig_cond_w4 (
    .clk(clk), .rst(rst), .pin_i(pin), .pol_inv(pol), .psc_sel(psc),
    .flt_code(code), .smp_tick(tick), .ext_mode_en(ext), .cnt_en(cen),
    .trig_o(trig_w), .count_o(cnt_w)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic ref_level();
    if (psc == 2'd0) return pin ^ pol;
    return logic'((ref_pe >> (psc - 1)) & 1);
  endfunction

  // Behavioural reference, advanced on every clock edge.
  always @(posedge clk) begin
    logic lvl, fcur;
    started = 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_flt = 0; m_fq = 0; m_cnt = '0;
      m_dc = int'(code) + 1;
    end else begin
      lvl  = ref_level();
      fcur = (code == 0) ? m_s2 : m_flt;
      if (fcur && !m_fq && ext && cen) m_cnt = m_cnt + 1'b1;
      m_fq = fcur;
      if (code == 0) begin
        m_flt = m_s2; m_dc = int'(code) + 1;
      end else if (tick) begin
        if (m_s2 != m_flt) begin
          if (m_dc <= 1) begin m_flt = m_s2; m_dc = int'(code) + 1; end
          else m_dc = m_dc - 1;
        end else m_dc = int'(code) + 1;
      end
      m_s2 = m_s1;
      m_s1 = lvl;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R4/R7 per-cycle count", int'(cnt), int'(m_cnt));
      check("R9 per-cycle narrow count", int'(cnt_w), int'(m_cnt[3:0]));
      check("R5/R6 per-cycle trigger", int'(trig),
            int'((code == 0) ? m_s2 : m_flt));
    end
  end

  // sampling tick generator
  always begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc++;
      tick = (tick_div <= 1) ? 1'b1 : ((tc % tick_div) == 0);
    end
  end

  task automatic set_pin(input logic v);
    if (!(pin ^ pol) && (v ^ pol)) ref_pe++;
    pin = v;
  endtask

  task automatic act_pulse(input int hi, input int lo);
    @(posedge clk); #1;
    set_pin(~pol);
    repeat (hi) @(posedge clk);
    #1 set_pin(pol);
    repeat (lo) @(posedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) act_pulse(hi, lo);
  endtask

  task automatic fast_burst(input int n);
    @(posedge clk); #1;
    for (int i = 0; i < 2 * n; i++) begin
      set_pin(~pin);
      #2.5;
    end
  endtask

  task automatic settle();
    repeat (14) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic npol, input logic [1:0] npsc);
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 pol = npol; psc = npsc; pin = npol;
    repeat (3) @(posedge clk);
    #1 rst = 0; ref_pe = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic new_psc(input logic [1:0] s);
    @(posedge clk); #1 psc = s; ref_pe = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired before the sequence ended (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (2) @(posedge clk); #1;
    check("R10 reset count", int'(cnt), 0);
    check("R10 reset trigger", int'(trig), 0);

    // R5, R7: unfiltered, undivided
    pulses(6, 3, 3); settle(); exp_total += 6;
    check("R5 R7 six pulses", int'(cnt), exp_total);

    // R4: latency from pin edge
    @(posedge clk); #1 set_pin(1); c0 = int'(cnt);
    @(posedge clk); #1 check("R4 trigger after first edge", int'(trig), 0);
    @(posedge clk); #1 check("R4 trigger after second edge", int'(trig), 1);
    check("R4 count after second edge", int'(cnt), c0);
    @(posedge clk); #1 check("R4 count after third edge", int'(cnt), c0 + 1);
    repeat (2) @(posedge clk); #1 set_pin(0);
    settle(); exp_total += 1;

    // R2: divide ratios
    new_psc(2'd1); pulses(10, 3, 3); settle(); exp_total += 5;
    check("R2 divide by 2", int'(cnt), exp_total);
    new_psc(2'd2); pulses(8, 3, 3); settle(); exp_total += 2;
    check("R2 divide by 4", int'(cnt), exp_total);
    new_psc(2'd3); pulses(16, 3, 3); settle(); exp_total += 2;
    check("R2 divide by 8", int'(cnt), exp_total);

    // R3: ratio change clears the divider
    new_psc(2'd2); pulses(3, 3, 3); settle(); exp_total += 1;
    check("R3 three edges at /4", int'(cnt), exp_total);
    new_psc(2'd1); pulses(1, 3, 3); settle(); exp_total += 1;
    check("R3 first edge after change to /2", int'(cnt), exp_total);
    new_psc(2'd0);

    // R1: inverted polarity, reset again (R10)
    do_reset(1'b1, 2'd0); #1;
    exp_total = 0;
    check("R10 count after second reset", int'(cnt), 0);
    check("R10 trigger after second reset", int'(trig), 0);
    @(posedge clk); #1 set_pin(0);
    repeat (6) @(posedge clk); #1;
    check("R1 falling pin edge counts", int'(cnt), 1);
    set_pin(1); settle();
    check("R1 rising pin edge ignored", int'(cnt), 1);
    exp_total = 1;
    pulses(4, 3, 3); settle(); exp_total += 4;
    check("R1 inverted pulses", int'(cnt), exp_total);

    // R8: enables
    @(posedge clk); #1 ext = 0;
    pulses(4, 3, 3); settle();
    check("R8 external mode off", int'(cnt), exp_total);
    ext = 1; cen = 0;
    pulses(4, 3, 3); settle();
    check("R8 counter off", int'(cnt), exp_total);
    cen = 1;
    pulses(4, 3, 3); settle(); exp_total += 4;
    check("R8 enables back on", int'(cnt), exp_total);

    // R6: filter code 3 with a tick every cycle
    code = 4'd3; repeat (3) @(posedge clk);
    pulses(3, 2, 6); settle();
    check("R6 short glitches rejected", int'(cnt), exp_total);
    pulses(2, 8, 8); settle(); exp_total += 2;
    check("R6 long pulses accepted", int'(cnt), exp_total);
    // R6: filter code 1 with a tick every other cycle
    code = 4'd1; tick_div = 2; repeat (3) @(posedge clk);
    pulses(2, 1, 6); settle();
    check("R6 one-cycle pulse rejected", int'(cnt), exp_total);
    pulses(2, 8, 8); settle(); exp_total += 2;
    check("R6 pulses over two ticks accepted", int'(cnt), exp_total);
    code = 4'd0; tick_div = 1; repeat (3) @(posedge clk);

    // R11: fast pin divided by 8
    new_psc(2'd3); fast_burst(64); settle(); exp_total += 8;
    check("R11 fast pin at /8", int'(cnt), exp_total);
    new_psc(2'd0);

    // R9: wrap of the narrow instance
    pulses(20, 3, 3); settle(); exp_total += 20;
    check("R9 wide total", int'(cnt), exp_total);
    check("R9 narrow wrapped", int'(cnt_w), exp_total % 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule